// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small CPU core. It takes the interrupt flags raised by peripherals and a register of per-source enable bits, and works out whether an interrupt should be taken and which one. It also produces the program address the core jumps to. Sources are numbered from zero. Source `i` owns vector slot `i+1`, and slot 0 belongs to reset. Because the lowest pending slot wins, slot order is the priority order.

A global enable bit gates every source. Hardware clears it in the cycle an interrupt is accepted, and a return-from-interrupt strobe sets it again. Software may set or clear it at any time, so a handler can re-open the gate and let nested interrupts in. A table-select input moves the vector table to the boot section. A separate input moves the reset vector to the same place, and the two settings are independent. A lock input masks every source while the core runs in a protected region.

The accept handshake works as follows. The controller raises `irq_req_o` together with the vector and the source index. When the core answers with `irq_ack_i` in that same cycle, the controller pulses a one-hot clear for the accepted flag and drops the global enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `irq_req_o` is high only when some source `i` has its flag, its enable bit and the global enable all at 1.
- R2: When several sources qualify, `irq_id_o` is the lowest qualifying index `i`.
- R3: `irq_vec_o` equals base + (i+1)*ENTRY_SIZE. The base is 0 when `vec_boot_i` is 0 and BOOT_BASE when it is 1.
- R4: An accept (`irq_req_o` and `irq_ack_i` high in the same cycle) makes `gie_o` read 0 from the next cycle on.
- R5: `gie_set_i` sets and `gie_clr_i` clears the global enable on the next edge. After a set inside a handler, a qualifying source raises `irq_req_o` again, which allows nesting.
- R6: `reti_i` sets the global enable on the next edge.
- R7: `reset_vec_o` is BOOT_BASE when `rst_boot_i` is 1 and 0 otherwise, whatever the value of `vec_boot_i`.
- R8: While reset is asserted and right after it, `en_o` and `gie_o` are 0 and `irq_req_o` is 0.
- R9: `flag_clr_o` is the one-hot bit of `irq_id_o` during an accept and all-zero in every other cycle. An `irq_ack_i` with no request clears nothing.
- R10: While `lock_i` is 1, `irq_req_o` is 0 whatever the global enable is.
- R11: When events coincide, an accept beats every set, and `gie_clr_i` beats both `gie_set_i` and `reti_i`.
- R12: A pulse on `en_wr_i` loads `en_wdata_i` into the enable register, and `en_o` shows the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_flag_i | input | NUM_SRC | Interrupt flags, bit i is source i |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_SRC | Enable register write data |
| gie_set_i | input | 1 | Software set of the global enable |
| gie_clr_i | input | 1 | Software clear of the global enable |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_boot_i | input | 1 | Place the vector table at BOOT_BASE |
| rst_boot_i | input | 1 | Place the reset vector at BOOT_BASE |
| lock_i | input | 1 | Mask all sources (protected region) |
| irq_ack_i | input | 1 | Core accepts the offered interrupt |
| irq_req_o | output | 1 | Interrupt offered to the core |
| irq_id_o | output | IDX_W | Index of the offered source |
| irq_vec_o | output | ADDR_W | Vector address of the offered source |
| flag_clr_o | output | NUM_SRC | One-hot clear of the accepted flag |
| reset_vec_o | output | ADDR_W | First fetch address after reset |
| en_o | output | NUM_SRC | Enable register contents |
| gie_o | output | 1 | Global enable bit |

## Verification
The global enable can receive several updates in one cycle: an accept, a return strobe and software writes can all land together. The bench provokes this by raising `irq_ack_i` during a live request in the same cycle as `reti_i`, and by pairing `gie_clr_i` with `gie_set_i` and with `reti_i`. In each case it reads `gie_o` one edge later and compares it with the priority order given in R11. An enable-register write is also issued in the same cycle as an accept, and the bench checks that the new value lands while the global enable still falls.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_SET  = 2'd1,
    GIE_CLR  = 2'd2
  } gie_op_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               accept_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] clr_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    assign clr_o[g] = accept_i && (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int NUM_SRC    = 8,
  parameter int ADDR_W     = 16,
  parameter int ENTRY_SIZE = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              vec_boot_i,
  input  logic              rst_boot_i,
  output logic [ADDR_W-1:0] vec_o,
  output logic [ADDR_W-1:0] reset_vec_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  assign base        = vec_boot_i ? BOOT_BASE : '0;
  assign offs        = (ADDR_W'(idx_i) + ADDR_W'(1)) * ADDR_W'(ENTRY_SIZE);
  assign vec_o       = base + offs;
  assign reset_vec_o = rst_boot_i ? BOOT_BASE : '0;
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic reti_i,
  output logic gie_o
);
  gie_op_e op;

  // accept > sw clear > (sw set | reti)
  always_comb begin
    if (accept_i || sw_clr_i)    op = GIE_CLR;
    else if (sw_set_i || reti_i) op = GIE_SET;
    else                         op = GIE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gie_o <= 1'b0;
    else begin
      unique case (op)
        GIE_SET: gie_o <= 1'b1;
        GIE_CLR: gie_o <= 1'b0;
        default: gie_o <= gie_o;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_SRC    = 8,
  parameter int ADDR_W     = 16,
  parameter int ENTRY_SIZE = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_flag_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               vec_boot_i,
  input  logic               rst_boot_i,
  input  logic               lock_i,
  input  logic               irq_ack_i,
  output logic               irq_req_o,
  output logic [IDX_W-1:0]   irq_id_o,
  output logic [ADDR_W-1:0]  irq_vec_o,
  output logic [NUM_SRC-1:0] flag_clr_o,
  output logic [ADDR_W-1:0]  reset_vec_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend;
  logic               gate;
  logic               accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  assign gate   = gie_o && !lock_i;
  assign pend   = irq_flag_i & en_q & {NUM_SRC{gate}};
  assign accept = irq_req_o && irq_ack_i;
  assign en_o   = en_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend_i   (pend),
    .accept_i (accept),
    .any_o    (irq_req_o),
    .idx_o    (irq_id_o),
    .clr_o    (flag_clr_o)
  );

  irq_vec_calc #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .ENTRY_SIZE (ENTRY_SIZE),
    .BOOT_BASE  (BOOT_BASE)
  ) u_vec (
    .idx_i       (irq_id_o),
    .vec_boot_i  (vec_boot_i),
    .rst_boot_i  (rst_boot_i),
    .vec_o       (irq_vec_o),
    .reset_vec_o (reset_vec_o)
  );

  irq_gie_ctrl u_gie (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .sw_set_i (gie_set_i),
    .sw_clr_i (gie_clr_i),
    .reti_i   (reti_i),
    .gie_o    (gie_o)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_flag_i,
  input logic               gie_set_i,
  input logic               gie_clr_i,
  input logic               reti_i,
  input logic               lock_i,
  input logic               irq_ack_i,
  input logic               irq_req_o,
  input logic [NUM_SRC-1:0] flag_clr_o,
  input logic [NUM_SRC-1:0] en_o,
  input logic               gie_o
);
  AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (gie_o && ((irq_flag_i & en_o) != '0))); // R1
  AST_ACCEPT_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> !gie_o); // R4
  AST_RETI_SETS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !gie_clr_i && !(irq_req_o && irq_ack_i)) |=> gie_o); // R6
  AST_SWCLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_clr_i && (gie_set_i || reti_i)) |=> !gie_o); // R11
  AST_LOCK_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> !irq_req_o); // R10
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_o)); // R9
  AST_CLR_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_o != '0) |-> (irq_ack_i && irq_req_o && ((flag_clr_o & irq_flag_i) != '0))); // R9
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_flag_i (irq_flag_i),
  .gie_set_i  (gie_set_i),
  .gie_clr_i  (gie_clr_i),
  .reti_i     (reti_i),
  .lock_i     (lock_i),
  .irq_ack_i  (irq_ack_i),
  .irq_req_o  (irq_req_o),
  .flag_clr_o (flag_clr_o),
  .en_o       (en_o),
  .gie_o      (gie_o)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int ES = 4;
  localparam logic [AW-1:0] BB = 16'h1E00;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] flag = '0, en_wd = '0;
  logic en_wr = 0, gset = 0, gclr = 0, reti = 0, vboot = 0, rboot = 0, lock = 0, ack = 0;
  logic req, gie;
  logic [IW-1:0] id;
  logic [AW-1:0] vec, rvec;
  logic [N-1:0] clr, en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .ENTRY_SIZE(ES), .BOOT_BASE(BB)) u_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_flag_i(flag), .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .gie_set_i(gset), .gie_clr_i(gclr), .reti_i(reti), .vec_boot_i(vboot),
    .rst_boot_i(rboot), .lock_i(lock), .irq_ack_i(ack), .irq_req_o(req),
    .irq_id_o(id), .irq_vec_o(vec), .flag_clr_o(clr), .reset_vec_o(rvec),
    .en_o(en), .gie_o(gie)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    // R8 reset state
    tick();
    chk("R8 en", en, 0); chk("R8 gie", gie, 0); chk("R8 req", req, 0);
    rst_n = 1; tick();
    chk("R8 en post", en, 0); chk("R8 gie post", gie, 0);
    // R7 reset vector independent of table select
    chk("R7 rvec default", rvec, 0);
    rboot = 1; vboot = 0; #1 chk("R7 rvec boot", rvec, BB);
    rboot = 0; vboot = 1; #1 chk("R7 rvec indep", rvec, 0);
    vboot = 0;
    // R5 software set
    gset = 1; tick(); gset = 0;
    chk("R5 gie set", gie, 1);
    // R1 R2 R3 R12 sweep
    for (int e = 0; e < 16; e++) begin
      en_wd = e[N-1:0]; en_wr = 1; tick(); en_wr = 0;
      chk("R12 en write", en, e);
      for (int f = 0; f < 16; f++) begin
        for (int vb = 0; vb < 2; vb++) begin
          int p, k;
          flag = f[N-1:0]; vboot = vb[0]; #1;
          p = f & e;
          chk("R1 req", req, (p != 0));
          if (p != 0) begin
            k = 0;
            while (!p[k]) k++;
            chk("R2 id", id, k);
            chk("R3 vec", vec, (vb ? BB : 0) + (k + 1) * ES);
          end
        end
      end
    end
    vboot = 0;
    // R12: no write strobe, no change
    en_wd = 4'h0; tick(); chk("R12 hold", en, 4'hF);
    // R10 lock
    flag = 4'hF; lock = 1; #1 chk("R10 lock", req, 0);
    lock = 0; #1 chk("R10 unlock", req, 1);
    // R5 clear gates
    gclr = 1; tick(); gclr = 0;
    chk("R5 gie clr", gie, 0); chk("R1 no gie", req, 0);
    // R9 ack without request clears nothing
    ack = 1; #1 chk("R9 stray ack", clr, 0);
    tick(); ack = 0; chk("R9 stray ack gie", gie, 0);
    gset = 1; tick(); gset = 0;
    // R9 R4 accept
    flag = 4'b0110; ack = 1; #1;
    chk("R9 clr onehot", clr, 4'b0010); chk("R2 id acc", id, 1);
    tick(); ack = 0;
    chk("R4 gie cleared", gie, 0); chk("R9 clr idle", clr, 0); chk("R4 req off", req, 0);
    // R5 nesting: handler re-enables
    gset = 1; tick(); gset = 0;
    chk("R5 nest req", req, 1); chk("R5 nest id", id, 1);
    // R6 reti
    gclr = 1; tick(); gclr = 0;
    reti = 1; tick(); reti = 0;
    chk("R6 reti sets", gie, 1);
    // R11 accept + reti same cycle, with enable write
    ack = 1; reti = 1; en_wr = 1; en_wd = 4'b1000; tick();
    ack = 0; reti = 0; en_wr = 0;
    chk("R11 accept beats reti", gie, 0); chk("R12 write on accept", en, 4'b1000);
    // R11 clr beats set
    gset = 1; gclr = 1; tick(); gset = 0; gclr = 0;
    chk("R11 clr beats set", gie, 0);
    reti = 1; gclr = 1; tick(); reti = 0; gclr = 0;
    chk("R11 clr beats reti", gie, 0);
    gset = 1; reti = 1; tick(); gset = 0; reti = 0;
    chk("R11 set+reti", gie, 1);
    flag = 4'b1000; #1;
    chk("R3 top vec", vec, 4 * ES); chk("R2 top id", id, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule